// File: doc/BRIEF.md
# In-band XON/XOFF Flow Controller

This block carries out software (in-band) flow control beside a UART. On the receive side it watches every received byte. It compares the byte against four programmed characters: two resume characters and two stop characters. A stop character holds the local transmitter, and a resume character lets it run again. Flow characters that match are taken out of the received stream. Every other byte goes on to the receive data path. The block can also raise a flow-control interrupt when it detects a flow character.

On the transmit side it sits between the transmit queue and the transmitter. A request to send a resume or stop character is placed ahead of queued data at the next byte boundary, and the receive hold does not block it. One 4-bit mode field sets the character choice for each direction: the first pair only, the second pair only, or both pairs as a two-byte sequence. An option lets any received byte end a hold.

Top module: `inband_flow_ctrl`

## Requirements
- R1: After reset, `tx_hold`, `flow_status`, `irq_code`, both pass lanes and `tx_is_flow` are 0.
- R2: With `mode[1:0]`=00, every received byte appears on pass lane 0 one cycle after its strobe, and the hold is never set.
- R3: With `mode[1:0]`=10 (stop1/resume1) or 01 (stop2/resume2), a byte equal to the selected stop character sets `tx_hold` and `flow_status` bit 3 (0x08) in the next cycle. The stop comparison wins when the stop and resume characters are equal.
- R4: In the same single modes, a byte equal to the selected resume character clears the hold in the next cycle.
- R5: While `tx_hold` is 1, queued data is neither presented on `tx_valid` nor popped.
- R6: With `mode[1:0]`=11, a byte equal to stop1 or resume1 is held as a partial match. A following stop2 or resume2 completes it. Any other following byte cancels the match, and the next cycle shows the held byte on lane 0 and the new byte on lane 1.
- R7: Matched flow characters, including a held first byte of a completed pair, never show up on either pass lane.
- R8: When `irq_en` is 1, a completed match sets `irq_code` to 0x10 in the next cycle. It stays until `irq_ack`, and a new match wins over an ack in the same cycle.
- R9: When `xon_any` is 1, any received byte clears the hold, unless that byte completes a stop match.
- R10: `mode[3:2]` selects what is transmitted: 00 drops requests, 10 sends resume1/stop1, 01 sends resume2/stop2, and 11 sends the first character and then the second.
- R11: A pending flow character is shown with `tx_is_flow`=1 ahead of queued data, even under hold, and is consumed when `tx_ready` is 1. A new request restarts the sequence, and the stop request wins when both requests arrive together.
- R12: When the last character of a stop sequence is accepted, `flow_status` bit 4 (0x10) is set in the next cycle. It is cleared when the last character of a resume sequence is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 4 | [3:2] transmit selection, [1:0] receive selection |
| xon_any | input | 1 | Any received byte ends a hold |
| irq_en | input | 1 | Flow-control interrupt enable |
| irq_ack | input | 1 | Clears the pending interrupt |
| xon1_ch | input | W | Resume character 1 |
| xon2_ch | input | W | Resume character 2 |
| xoff1_ch | input | W | Stop character 1 |
| xoff2_ch | input | W | Stop character 2 |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | W | Received byte |
| pass0_valid | output | 1 | Forwarded byte on lane 0 (earlier byte) |
| pass0_byte | output | W | Lane 0 data |
| pass1_valid | output | 1 | Forwarded byte on lane 1 (later byte) |
| pass1_byte | output | W | Lane 1 data |
| send_xon | input | 1 | Request to transmit a resume sequence |
| send_xoff | input | 1 | Request to transmit a stop sequence |
| q_valid | input | 1 | Transmit queue has a byte |
| q_byte | input | W | Head of the transmit queue |
| q_pop | output | 1 | Queue head taken by the transmitter |
| tx_ready | input | 1 | Transmitter takes a byte this cycle |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | W | Offered byte |
| tx_is_flow | output | 1 | Offered byte is a flow character |
| tx_hold | output | 1 | Transmitter held by a received stop |
| flow_status | output | 8 | Bit 3 hold, bit 4 stop sent |
| irq_code | output | 8 | 0x10 while a flow interrupt is pending |

## Verification
The bench builds the block with the default 8-bit character width. It uses distinct values for the four characters, so single and pair matching can be told apart, and in one phase it sets resume1 equal to stop1 to reach the stop-first priority. The reference model predicts both pass lanes, the hold, the status bits, the interrupt and the transmit mux in every cycle. This makes it possible to check partial-match cancellation, restarted send sequences and mode changes while a character is pending.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic [1:0] {FK_NONE = 2'd0, FK_XON = 2'd1, FK_XOFF = 2'd2} flow_kind_e;

  localparam logic [1:0] FM_OFF    = 2'b00;
  localparam logic [1:0] FM_FIRST  = 2'b10;
  localparam logic [1:0] FM_SECOND = 2'b01;
  localparam logic [1:0] FM_BOTH   = 2'b11;

  localparam int STAT_HOLD_BIT = 3;
  localparam int STAT_SENT_BIT = 4;
  localparam logic [7:0] IRQ_FLOW_CODE = 8'h10;

  // Which character set a given step of a send sequence draws from.
  function automatic logic uses_second(input logic [1:0] m, input logic step);
    return (m == FM_SECOND) || ((m == FM_BOTH) && step);
  endfunction

  // True when this step ends the sequence.
  function automatic logic step_is_last(input logic [1:0] m, input logic step);
    return (m != FM_BOTH) || step;
  endfunction
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   rx_mode,
  input  logic         xon_any,
  input  logic [W-1:0] xon1_ch,
  input  logic [W-1:0] xon2_ch,
  input  logic [W-1:0] xoff1_ch,
  input  logic [W-1:0] xoff2_ch,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         hit_on,
  output logic         hit_off,
  output logic         pass0_valid,
  output logic [W-1:0] pass0_byte,
  output logic         pass1_valid,
  output logic [W-1:0] pass1_byte,
  output logic         hold
);
  import swfc_pkg::*;

  logic         armed_q;
  flow_kind_e   arm_kind_q, arm_kind_d;
  logic [W-1:0] held_q;
  logic         arm_d, fwd_held, fwd_new;
  logic [W-1:0] on_sel, off_sel;

  assign on_sel  = (rx_mode == FM_SECOND) ? xon2_ch  : xon1_ch;
  assign off_sel = (rx_mode == FM_SECOND) ? xoff2_ch : xoff1_ch;

  always_comb begin
    hit_on = 1'b0; hit_off = 1'b0; arm_d = 1'b0; arm_kind_d = FK_NONE;
    fwd_held = 1'b0; fwd_new = 1'b0;
    if (rx_valid) begin
      if (armed_q) begin
        if (rx_mode == FM_BOTH && arm_kind_q == FK_XOFF && rx_byte == xoff2_ch) hit_off = 1'b1;
        else if (rx_mode == FM_BOTH && arm_kind_q == FK_XON && rx_byte == xon2_ch) hit_on = 1'b1;
        else begin fwd_held = 1'b1; fwd_new = 1'b1; end
      end else if (rx_mode == FM_OFF) begin
        fwd_new = 1'b1;
      end else if (rx_mode == FM_BOTH) begin
        if (rx_byte == xoff1_ch)     begin arm_d = 1'b1; arm_kind_d = FK_XOFF; end
        else if (rx_byte == xon1_ch) begin arm_d = 1'b1; arm_kind_d = FK_XON;  end
        else fwd_new = 1'b1;
      end else begin
        if (rx_byte == off_sel)     hit_off = 1'b1;
        else if (rx_byte == on_sel) hit_on  = 1'b1;
        else fwd_new = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; arm_kind_q <= FK_NONE; held_q <= '0; hold <= 1'b0;
      pass0_valid <= 1'b0; pass0_byte <= '0; pass1_valid <= 1'b0; pass1_byte <= '0;
    end else begin
      if (rx_valid) begin
        armed_q    <= arm_d;
        arm_kind_q <= arm_kind_d;
      end
      if (arm_d) held_q <= rx_byte;
      pass0_valid <= fwd_held | fwd_new;
      pass0_byte  <= fwd_held ? held_q : rx_byte;
      pass1_valid <= fwd_held;
      pass1_byte  <= rx_byte;
      if (hit_off) hold <= 1'b1;
      else if (hit_on || (xon_any && rx_valid)) hold <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   tx_mode,
  input  logic [W-1:0] xon1_ch,
  input  logic [W-1:0] xon2_ch,
  input  logic [W-1:0] xoff1_ch,
  input  logic [W-1:0] xoff2_ch,
  input  logic         send_xon,
  input  logic         send_xoff,
  input  logic         hold,
  input  logic         q_valid,
  input  logic [W-1:0] q_byte,
  input  logic         tx_ready,
  output logic         q_pop,
  output logic         tx_valid,
  output logic [W-1:0] tx_byte,
  output logic         tx_is_flow,
  output logic         xoff_done,
  output logic         xoff_sent
);
  import swfc_pkg::*;

  flow_kind_e   pend_q;
  logic         step_q;
  logic         sec, flow_accept, flow_last;
  logic [W-1:0] flow_char;

  always_comb begin
    sec       = uses_second(tx_mode, step_q);
    flow_char = (pend_q == FK_XOFF) ? (sec ? xoff2_ch : xoff1_ch) : (sec ? xon2_ch : xon1_ch);
  end

  assign tx_is_flow  = (pend_q != FK_NONE);
  assign tx_valid    = tx_is_flow || (q_valid && !hold);
  assign tx_byte     = tx_is_flow ? flow_char : q_byte;
  assign q_pop       = !tx_is_flow && q_valid && !hold && tx_ready;
  assign flow_accept = tx_is_flow && tx_ready;
  assign flow_last   = flow_accept && step_is_last(tx_mode, step_q);
  assign xoff_done   = flow_last && (pend_q == FK_XOFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= FK_NONE; step_q <= 1'b0; xoff_sent <= 1'b0;
    end else begin
      if (flow_last) pend_q <= FK_NONE;
      else if (flow_accept) step_q <= 1'b1;
      if (xoff_done) xoff_sent <= 1'b1;
      else if (flow_last) xoff_sent <= 1'b0;
      if (tx_mode == FM_OFF) pend_q <= FK_NONE;
      else if (send_xoff) begin pend_q <= FK_XOFF; step_q <= 1'b0; end
      else if (send_xon)  begin pend_q <= FK_XON;  step_q <= 1'b0; end
    end
  end
endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic         xon_any,
  input  logic         irq_en,
  input  logic         irq_ack,
  input  logic [W-1:0] xon1_ch,
  input  logic [W-1:0] xon2_ch,
  input  logic [W-1:0] xoff1_ch,
  input  logic [W-1:0] xoff2_ch,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         pass0_valid,
  output logic [W-1:0] pass0_byte,
  output logic         pass1_valid,
  output logic [W-1:0] pass1_byte,
  input  logic         send_xon,
  input  logic         send_xoff,
  input  logic         q_valid,
  input  logic [W-1:0] q_byte,
  output logic         q_pop,
  input  logic         tx_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_byte,
  output logic         tx_is_flow,
  output logic         tx_hold,
  output logic [7:0]   flow_status,
  output logic [7:0]   irq_code
);
  import swfc_pkg::*;

  logic hit_on, hit_off, xoff_done, xoff_sent, irq_q;

  swfc_rx_match #(.W(W)) u_rx (
    .clk, .rst_n, .rx_mode(mode[1:0]), .xon_any,
    .xon1_ch, .xon2_ch, .xoff1_ch, .xoff2_ch,
    .rx_valid, .rx_byte, .hit_on, .hit_off,
    .pass0_valid, .pass0_byte, .pass1_valid, .pass1_byte, .hold(tx_hold)
  );

  swfc_tx_inject #(.W(W)) u_tx (
    .clk, .rst_n, .tx_mode(mode[3:2]),
    .xon1_ch, .xon2_ch, .xoff1_ch, .xoff2_ch,
    .send_xon, .send_xoff, .hold(tx_hold), .q_valid, .q_byte, .tx_ready,
    .q_pop, .tx_valid, .tx_byte, .tx_is_flow, .xoff_done, .xoff_sent
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (irq_en && (hit_on || hit_off)) irq_q <= 1'b1;
    else if (irq_ack) irq_q <= 1'b0;
  end

  always_comb begin
    flow_status = '0;
    flow_status[STAT_HOLD_BIT] = tx_hold;
    flow_status[STAT_SENT_BIT] = xoff_sent;
    irq_code = irq_q ? IRQ_FLOW_CODE : 8'h00;
  end
endmodule

// File: rtl/inband_flow_ctrl_chk.sv
module inband_flow_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hit_on,
  input logic       hit_off,
  input logic       tx_hold,
  input logic       pass0_valid,
  input logic       pass1_valid,
  input logic       irq_en,
  input logic [7:0] irq_code,
  input logic       q_pop,
  input logic       tx_is_flow,
  input logic       xoff_done,
  input logic [7:0] flow_status
);
  assert_xoff_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> tx_hold);
  assert_xon_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_on |=> !tx_hold);
  assert_hold_blocks_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |-> !q_pop);
  assert_lane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass1_valid |-> pass0_valid);
  assert_match_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_on || hit_off) |=> !pass0_valid);
  assert_irq_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (hit_on || hit_off)) |=> (irq_code == 8'h10));
  assert_flow_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_flow |-> !q_pop);
  assert_xoff_sent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_done |=> flow_status[4]);
endmodule

bind inband_flow_ctrl inband_flow_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit_on(hit_on), .hit_off(hit_off), .tx_hold(tx_hold),
  .pass0_valid(pass0_valid), .pass1_valid(pass1_valid), .irq_en(irq_en),
  .irq_code(irq_code), .q_pop(q_pop), .tx_is_flow(tx_is_flow),
  .xoff_done(xoff_done), .flow_status(flow_status)
);

// File: tb/test_inband_flow_ctrl.sv
`timescale 1ns/1ps
module test_inband_flow_ctrl;
  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 0;
  logic xon_any = 0, irq_en = 0, irq_ack = 0;
  logic [7:0] xon1_ch = 8'h11, xon2_ch = 8'h91, xoff1_ch = 8'h13, xoff2_ch = 8'h93;
  logic rx_valid = 0; logic [7:0] rx_byte = 0;
  logic pass0_valid, pass1_valid; logic [7:0] pass0_byte, pass1_byte;
  logic send_xon = 0, send_xoff = 0, q_valid = 0, tx_ready = 0;
  logic [7:0] q_byte = 0;
  logic q_pop, tx_valid, tx_is_flow, tx_hold;
  logic [7:0] tx_byte, flow_status, irq_code;

  always #2.5 clk = ~clk;

  inband_flow_ctrl i_inband_flow_ctrl (.*);

  int n_tests = 0, n_fail = 0;

  // reference state
  int m_hold, m_arm, m_held, m_p0v, m_p0, m_p1v, m_p1, m_irq, m_sent, m_pk, m_step;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int flow_char();
    int txm = mode[3:2];
    bit sec = (txm == 1) || (txm == 3 && m_step == 1);
    if (m_pk == 2) return sec ? xoff2_ch : xoff1_ch;
    return sec ? xon2_ch : xon1_ch;
  endfunction

  task automatic compare();
    int fl = (m_pk != 0);
    int tv = fl || (q_valid && !m_hold);
    chk("R7 lane0", {pass0_valid, pass0_valid ? pass0_byte : 8'h0}, {m_p0v[0], m_p0v ? m_p0[7:0] : 8'h0});
    chk("R6 lane1", {pass1_valid, pass1_valid ? pass1_byte : 8'h0}, {m_p1v[0], m_p1v ? m_p1[7:0] : 8'h0});
    chk("R3 hold", tx_hold, m_hold);
    chk("R12 status", flow_status, (m_hold << 3) | (m_sent << 4));
    chk("R8 irq", irq_code, m_irq ? 8'h10 : 0);
    chk("R11 tx flags", {tx_valid, tx_is_flow}, {tv[0], fl[0]});
    if (tv) chk("R10 tx byte", tx_byte, fl ? flow_char() : q_byte);
    chk("R5 pop", q_pop, (!fl && q_valid && !m_hold && tx_ready));
  endtask

  task automatic model_step();
    int rxm = mode[1:0], txm = mode[3:2], b = rx_byte;
    bit on = 0, off = 0; int held_old = m_held;
    int fl = (m_pk != 0);
    m_p0v = 0; m_p1v = 0;
    if (rx_valid) begin
      if (m_arm != 0) begin
        if (rxm == 3 && m_arm == 2 && b == xoff2_ch) off = 1;
        else if (rxm == 3 && m_arm == 1 && b == xon2_ch) on = 1;
        else begin m_p0v = 1; m_p0 = held_old; m_p1v = 1; m_p1 = b; end
        m_arm = 0;
      end else if (rxm == 0) begin m_p0v = 1; m_p0 = b; end
      else if (rxm == 3) begin
        if (b == xoff1_ch) begin m_arm = 2; m_held = b; end
        else if (b == xon1_ch) begin m_arm = 1; m_held = b; end
        else begin m_p0v = 1; m_p0 = b; end
      end else begin
        int offc = (rxm == 1) ? xoff2_ch : xoff1_ch;
        int onc  = (rxm == 1) ? xon2_ch  : xon1_ch;
        if (b == offc) off = 1; else if (b == onc) on = 1;
        else begin m_p0v = 1; m_p0 = b; end
      end
    end
    if (irq_en && (on || off)) m_irq = 1; else if (irq_ack) m_irq = 0;
    if (fl && tx_ready) begin
      if (txm == 3 && m_step == 0) m_step = 1;
      else begin m_sent = (m_pk == 2); m_pk = 0; end
    end
    if (txm == 0) m_pk = 0;
    else if (send_xoff) begin m_pk = 2; m_step = 0; end
    else if (send_xon) begin m_pk = 1; m_step = 0; end
    if (off) m_hold = 1; else if (on || (xon_any && rx_valid)) m_hold = 0;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    rx_valid = 0; send_xon = 0; send_xoff = 0; irq_ack = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_hold = 0; m_arm = 0; m_held = 0; m_p0v = 0; m_p0 = 0; m_p1v = 0; m_p1 = 0;
    m_irq = 0; m_sent = 0; m_pk = 0; m_step = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 reset", {tx_hold, flow_status, irq_code, pass0_valid, pass1_valid, tx_is_flow}, 0);
    rst_n = 1;
    idle(2);
    // R2: pass-through mode, flow characters are plain data; R10 request dropped
    rx(8'h11); rx(8'h13); rx(8'h41); send_xoff = 1; cyc(); idle(2);
    // R3/R4/R5: single set 1
    mode = 4'b0010; q_valid = 1; q_byte = 8'h55; tx_ready = 1;
    rx(8'h93); rx(8'h13); idle(3); rx(8'h42); rx(8'h11); idle(2);
    // set 2
    mode = 4'b0001;
    rx(8'h13); rx(8'h93); idle(2); rx(8'h91); idle(1);
    // R6/R7 pair mode
    mode = 4'b0011;
    rx(8'h13); rx(8'h93); idle(1); rx(8'h11); rx(8'h91); idle(1);
    rx(8'h13); rx(8'h41); rx(8'h13); rx(8'h13); rx(8'h11); rx(8'h93); idle(2);
    // R8 interrupt
    irq_en = 1; rx(8'h13); rx(8'h93); idle(2); irq_ack = 1; cyc(); idle(1);
    rx(8'h11); rx_valid = 1; rx_byte = 8'h91; irq_ack = 1; cyc(); idle(1);
    irq_ack = 1; cyc(); irq_en = 0;
    // R9 any byte resumes
    mode = 4'b0010; rx(8'h13); xon_any = 1; idle(2); rx(8'h77); rx(8'h13); rx(8'h13); rx(8'h42);
    xon_any = 0;
    // R10/R11/R12 transmit injection, under hold
    rx(8'h13);
    mode = 4'b1010; tx_ready = 0; send_xoff = 1; cyc(); idle(2); tx_ready = 1; cyc(); idle(2);
    mode = 4'b0110; send_xon = 1; cyc(); idle(2);
    mode = 4'b1110; tx_ready = 0; send_xoff = 1; cyc(); tx_ready = 1; cyc(); tx_ready = 0; idle(2);
    tx_ready = 1; cyc(); idle(1);
    send_xon = 1; send_xoff = 1; cyc(); send_xon = 1; cyc(); idle(3);
    tx_ready = 0; send_xoff = 1; cyc(); mode = 4'b0010; idle(2); tx_ready = 1;
    rx(8'h11); idle(3);
    // R3 priority: equal stop and resume characters
    xon1_ch = 8'h13; rx(8'h13); idle(2); xon1_ch = 8'h11; rx(8'h11); idle(2);
    q_valid = 0; idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule